// File: doc/BRIEF.md
# Digit Sequence Combination Lock

This block is a synchronous state machine that watches a stream of 4-bit digits and opens a lock after it sees the digits 3, 8 and 4 one after another. A digit counts only in a cycle where the valid strobe is high. In any other cycle the machine keeps its state. A wrong digit sends the machine back to the start. The exception is a stray 3, which is always the first digit of a fresh attempt. Once the lock is open, the next valid digit of any value closes it again.

The next-state and output function comes in two forms, and a parameter picks one. `USE_TABLE = 0` uses plain gate-level decode. `USE_TABLE = 1` reads a 64-entry table indexed by the current state and the digit. Both forms have the same behaviour at the ports. The current state is brought out next to the unlock flag so that it can be observed.

Top module: `digit_lock`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) sets the state to 0 and drives `unlock` low. The reset takes priority over `digitValid`.
- R2: In state 0, a valid digit 3 moves the state to 1. Any other valid digit leaves the state at 0.
- R3: In state 1, a valid 8 moves the state to 2 and a valid 3 keeps the state at 1. Any other valid digit returns the state to 0.
- R4: In state 2, a valid 4 moves the state to 3 and a valid 3 moves the state to 1. Any other valid digit returns the state to 0.
- R5: `unlock` is high exactly when the state is 3.
- R6: In state 3, any valid digit, 3 included, returns the state to 0.
- R7: In a cycle with `digitValid` low, the state and `unlock` stay unchanged whatever value `digit` has.
- R8: Digit codes 10 to 15 never match, so they take the same fallback as any other wrong digit.
- R9: With `USE_TABLE = 1`, the function comes from a 64-entry table. The index is {state[1:0], digit[3:0]} and each entry is {next[1:0], unlock}. Example entries: index 0x00 holds 000, 0x03 holds 010, 0x13 holds 010, 0x18 holds 100, and every index 0x30 to 0x3F holds 001. Both values of `USE_TABLE` give identical state and unlock sequences for every input stream.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| digit | input | 4 | Digit presented this cycle |
| digitValid | input | 1 | Digit is taken when high |
| unlock | output | 1 | High while the lock is open (state 3) |
| state | output | 2 | Current state, 0 to 3 |

## Verification
The bench first runs the full code directly, then the code broken at each position. It then tries overlapping attempts such as 3,3,8,4 and 3,8,3,8,4 and digits of 10 and above. These patterns separate the fallback to state 1 from the fallback to state 0. Idle cycles are placed inside a code, carrying digits that would otherwise match, which shows that the strobe gates the state. The bench also tries a valid 3 while the lock is open, which separates the close-on-any-digit rule from a restart. A long random stream, weighted toward the digits 3, 8 and 4 and with random strobes, runs both implementations side by side against a behavioural model on every clock.

// File: rtl/lock_pkg.sv
package lock_pkg;
  localparam int DIGIT_W = 4;
  localparam int STATE_W = 2;
  localparam int TBL_IDX_W = STATE_W + DIGIT_W;
  localparam int TBL_DEPTH = 1 << TBL_IDX_W;
  localparam int ENTRY_W = STATE_W + 1;

  localparam logic [DIGIT_W-1:0] KEY_FIRST  = 4'd3;
  localparam logic [DIGIT_W-1:0] KEY_SECOND = 4'd8;
  localparam logic [DIGIT_W-1:0] KEY_THIRD  = 4'd4;

  localparam logic [STATE_W-1:0] ST_IDLE = 2'd0;
  localparam logic [STATE_W-1:0] ST_ONE  = 2'd1;
  localparam logic [STATE_W-1:0] ST_TWO  = 2'd2;
  localparam logic [STATE_W-1:0] ST_OPEN = 2'd3;

  typedef struct packed {
    logic clear;
    logic load;
  } lockStrobe_t;

  // Table entry for index {state, digit}: {next[1:0], unlock}
  function automatic logic [ENTRY_W-1:0] tableEntry(input logic [TBL_IDX_W-1:0] idx);
    logic [STATE_W-1:0] cur;
    logic [DIGIT_W-1:0] dig;
    logic [STATE_W-1:0] nxt;
    cur = idx[TBL_IDX_W-1:DIGIT_W];
    dig = idx[DIGIT_W-1:0];
    case (cur)
      ST_IDLE: nxt = (dig == KEY_FIRST) ? ST_ONE : ST_IDLE;
      ST_ONE:  nxt = (dig == KEY_SECOND) ? ST_TWO :
                     (dig == KEY_FIRST) ? ST_ONE : ST_IDLE;
      ST_TWO:  nxt = (dig == KEY_THIRD) ? ST_OPEN :
                     (dig == KEY_FIRST) ? ST_ONE : ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
    return {nxt, (cur == ST_OPEN)};
  endfunction
endpackage

// File: rtl/lock_ctrl.sv
module lock_ctrl
  import lock_pkg::*;
(
  input  logic        rst,
  input  logic        digitValid,
  output lockStrobe_t strobe
);
  always_comb begin
    strobe.clear = rst;
    strobe.load  = digitValid & ~rst;
  end
endmodule

// File: rtl/lock_next_logic.sv
module lock_next_logic
  import lock_pkg::*;
#(
  parameter bit USE_TABLE = 1'b0
) (
  input  logic [STATE_W-1:0] curState,
  input  logic [DIGIT_W-1:0] digit,
  output logic [STATE_W-1:0] nextState,
  output logic               unlockNow
);
  generate
    if (USE_TABLE) begin : g_table
      logic [ENTRY_W-1:0] tableMem [TBL_DEPTH];
      logic [ENTRY_W-1:0] entry;
      for (genvar i = 0; i < TBL_DEPTH; i++) begin : g_fill
        assign tableMem[i] = tableEntry(TBL_IDX_W'(i));
      end
      assign entry     = tableMem[{curState, digit}];
      assign nextState = entry[ENTRY_W-1:1];
      assign unlockNow = entry[0];
    end else begin : g_logic
      logic isFirst, isSecond, isThird;
      logic inIdle, inOne, inTwo;
      assign isFirst  = (digit == KEY_FIRST);
      assign isSecond = (digit == KEY_SECOND);
      assign isThird  = (digit == KEY_THIRD);
      assign inIdle   = (curState == ST_IDLE);
      assign inOne    = (curState == ST_ONE);
      assign inTwo    = (curState == ST_TWO);
      // one-hot targets, then encode
      logic goOne, goTwo, goOpen;
      assign goOne  = isFirst & (inIdle | inOne | inTwo);
      assign goTwo  = isSecond & inOne;
      assign goOpen = isThird & inTwo;
      assign nextState = {goTwo | goOpen, goOne | goOpen};
      assign unlockNow = (curState == ST_OPEN);
    end
  endgenerate
endmodule

// File: rtl/lock_datapath.sv
module lock_datapath
  import lock_pkg::*;
#(
  parameter bit USE_TABLE = 1'b0
) (
  input  logic               clk,
  input  lockStrobe_t        strobe,
  input  logic [DIGIT_W-1:0] digit,
  output logic [STATE_W-1:0] stateQ,
  output logic               unlock
);
  logic [STATE_W-1:0] nextState;

  lock_next_logic #(.USE_TABLE(USE_TABLE)) u_next (
    .curState (stateQ),
    .digit    (digit),
    .nextState(nextState),
    .unlockNow(unlock)
  );

  always_ff @(posedge clk) begin
    if (strobe.clear)     stateQ <= ST_IDLE;
    else if (strobe.load) stateQ <= nextState;
  end
endmodule

// File: rtl/digit_lock.sv
module digit_lock
  import lock_pkg::*;
#(
  parameter bit USE_TABLE = 1'b0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [DIGIT_W-1:0] digit,
  input  logic               digitValid,
  output logic               unlock,
  output logic [STATE_W-1:0] state
);
  lockStrobe_t strobe;

  lock_ctrl u_ctrl (
    .rst       (rst),
    .digitValid(digitValid),
    .strobe    (strobe)
  );

  lock_datapath #(.USE_TABLE(USE_TABLE)) u_dp (
    .clk   (clk),
    .strobe(strobe),
    .digit (digit),
    .stateQ(state),
    .unlock(unlock)
  );
endmodule

// File: rtl/digit_lock_chk.sv
module digit_lock_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] digit,
  input logic       digitValid,
  input logic       unlock,
  input logic [1:0] state
);
  AST_UNLOCK_OPEN: assert property (@(posedge clk) disable iff (rst)
    unlock == (state == 2'd3)); // R5
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !digitValid |=> $stable(state)); // R7
  AST_OPEN_CLOSE: assert property (@(posedge clk) disable iff (rst)
    (digitValid && state == 2'd3) |=> state == 2'd0); // R6
  AST_FIRST_KEY: assert property (@(posedge clk) disable iff (rst)
    (digitValid && digit == 4'd3 && state != 2'd3) |=> state == 2'd1); // R2
  AST_THIRD_KEY: assert property (@(posedge clk) disable iff (rst)
    (digitValid && digit == 4'd4 && state == 2'd2) |=> state == 2'd3); // R4
  AST_HIGH_CODE: assert property (@(posedge clk) disable iff (rst)
    (digitValid && digit > 4'd9) |=> state == 2'd0); // R8
endmodule

bind digit_lock digit_lock_chk u_chk (
  .clk(clk), .rst(rst), .digit(digit), .digitValid(digitValid),
  .unlock(unlock), .state(state)
);

// File: tb/digit_lock_tb.sv
module digit_lock_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] digit = 4'd0;
  logic       digitValid = 1'b0;
  logic       unlockA, unlockB;
  logic [1:0] stateA, stateB;

  int total = 0;
  int bad = 0;
  int refState = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  digit_lock #(.USE_TABLE(1'b0)) u_dut (
    .clk(clk), .rst(rst), .digit(digit), .digitValid(digitValid),
    .unlock(unlockA), .state(stateA)
  );
  digit_lock #(.USE_TABLE(1'b1)) u_dutTbl (
    .clk(clk), .rst(rst), .digit(digit), .digitValid(digitValid),
    .unlock(unlockB), .state(stateB)
  );

  function automatic int nextRef(int s, int d);
    if (s == 3) return 0;
    if (d == 3) return 1;
    if (s == 1 && d == 8) return 2;
    if (s == 2 && d == 4) return 3;
    return 0;
  endfunction

  // reference model, updated at the clock edge
  always @(posedge clk) begin
    if (rst) refState <= 0;
    else if (digitValid) refState <= nextRef(refState, int'(digit));
  end

  task automatic checkAll(string tag);
    total++;
    if (int'(stateA) != refState || unlockA != (refState == 3)) begin
      bad++;
      $display("FAIL %s logic variant: state=%0d unlock=%0d expected state=%0d unlock=%0d",
               tag, stateA, unlockA, refState, refState == 3);
    end
    total++;
    if (int'(stateB) != refState || unlockB != (refState == 3)) begin
      bad++;
      $display("FAIL %s/R9 table variant: state=%0d unlock=%0d expected state=%0d unlock=%0d",
               tag, stateB, unlockB, refState, refState == 3);
    end
  endtask

  // drive at negedge, check at the following negedge (after one posedge)
  task automatic step(input logic v, input int d, input string tag);
    digit = 4'(d);
    digitValid = v;
    @(negedge clk);
    checkAll(tag);
  endtask

  task automatic doReset();
    rst = 1'b1; digitValid = 1'b1; digit = 4'd3;
    @(negedge clk);
    rst = 1'b0; digitValid = 1'b0;
    checkAll("R1");
  endtask

  function automatic string tagFor(int s, logic v, int d);
    if (!v) return "R7";
    if (d > 9) return "R8";
    case (s)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      default: return "R6";
    endcase
  endfunction

  initial begin
    @(negedge clk);
    doReset();
    // full code, then open; R5 checked inside checkAll
    step(1, 3, "R2"); step(1, 8, "R3"); step(1, 4, "R4");
    step(0, 7, "R5"); step(0, 3, "R7");
    step(1, 3, "R6");
    // wrong digits
    step(1, 5, "R2"); step(1, 3, "R2"); step(1, 9, "R3");
    step(1, 3, "R2"); step(1, 3, "R3"); step(1, 8, "R3");
    step(1, 3, "R4"); step(1, 8, "R3"); step(1, 7, "R4");
    // overlapping 3,8,3,8,4
    step(1, 3, "R2"); step(1, 8, "R3"); step(1, 3, "R4");
    step(1, 8, "R3"); step(1, 4, "R4"); step(1, 0, "R6");
    // high codes
    step(1, 12, "R8"); step(1, 3, "R2"); step(1, 15, "R8");
    step(1, 3, "R2"); step(1, 8, "R3"); step(1, 10, "R8");
    // idle gaps with matching digits
    step(1, 3, "R2"); step(0, 8, "R7"); step(0, 4, "R7");
    step(1, 8, "R3"); step(0, 3, "R7"); step(1, 4, "R4");
    step(0, 3, "R7"); step(0, 0, "R7");
    // reset over open lock and over valid
    doReset();
    step(1, 3, "R2");
    doReset();
    // random stream
    for (int i = 0; i < 4000; i++) begin
      int r;
      int d;
      logic v;
      r = $urandom_range(0, 9);
      d = (r < 3) ? 3 : (r < 5) ? 8 : (r < 7) ? 4 : int'($urandom_range(0, 15));
      v = ($urandom_range(0, 9) < 7);
      step(v, d, tagFor(refState, v, d));
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: run did not complete");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule